// File: doc/BRIEF.md
# Pipelined Bus Slave With Request Queue

This block is a memory-mapped slave that uses a pipelined bus handshake. A master opens a transaction with the cycle input and issues requests with the strobe input, together with a write-enable, an address and write data. The slave takes a request on every clock edge where cycle and strobe are high and its stall output is low. Each request it takes goes into a small request FIFO. The master can therefore issue new requests while earlier ones are still being worked on.

A worker drains the FIFO one request at a time. It spends a fixed number of cycles on each request and then serves it from an internal register bank. It reports the completion with a one-cycle acknowledge from a flip-flop, and returns read data on that same cycle. Completions come back in the order the requests were taken. If the master drops the cycle input, every queued or unfinished request is discarded and produces no acknowledge.

Top module: `pbq_slave`

## Requirements
- R1: A request is accepted on a rising clock edge where `cyc_i` and `stb_i` are high and `stall_o` is low. `stall_o` depends only on internal state, so changing `stb_i`, `we_i`, `adr_i` or `dat_i` within a cycle never changes it.
- R2: `stall_o` is high exactly when the request FIFO holds `FIFO_DEPTH` entries. Strobes presented while `stall_o` is high are not accepted and produce no acknowledge. The number of accepted requests that are not yet acknowledged never exceeds `FIFO_DEPTH`+1.
- R3: A request accepted while the slave is empty is acknowledged `PROC_CYCLES`+1 clock edges after its acceptance edge. When requests are queued back to back, consecutive acknowledges are `PROC_CYCLES` edges apart.
- R4: Each accepted request produces exactly one acknowledge, and each acknowledge is high for a single cycle. Acknowledges come in acceptance order.
- R5: On the acknowledge of a read (`we_i`=0), `dat_o` holds the register bank word at the request's address. `dat_o` is zero on write acknowledges and whenever `ack_o` is low.
- R6: A write (`we_i`=1) stores `dat_i` into word `adr_i` of the register bank when it completes. A read that completes later sees the new value.
- R7: A clock edge with `cyc_i` low empties the FIFO and aborts the worker. `ack_o` is low after that edge. Writes that were discarded this way never reach the register bank.
- R8: After reset, `stall_o` and `ack_o` are low, `dat_o` is zero, and every register bank word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | Transaction open; low flushes all pending work |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Register bank word address |
| dat_i | input | DATA_W | Write data |
| stall_o | output | 1 | Back pressure: request FIFO full |
| ack_o | output | 1 | Registered completion pulse, one per accepted request |
| dat_o | output | DATA_W | Read data, valid while `ack_o` is high |

## Verification
The bench drives its inputs just after each falling edge. The request is accepted on the next rising edge, and the bench records it in its model queue at the moment it drives it. `ack_o` and `dat_o` set by a rising edge are read at the following falling edge. A request driven in step s is therefore acknowledged, on an empty slave, in step s+`PROC_CYCLES`+2, and back-to-back acknowledges fall `PROC_CYCLES` steps apart. `stall_o` is read before the drive and 1 ns after it, so any dependence on the new inputs shows up. A flush takes effect on the edge after the low `cyc_i` is driven, so the bench clears its queue in that same step and treats any later acknowledge for those requests as unexpected.

// File: rtl/pbq_pkg.sv
package pbq_pkg;
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_BUSY = 1'b1
  } wk_state_e;
endpackage

// File: rtl/pbq_fifo.sv
module pbq_fifo #(
  parameter int WIDTH = 37,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0] count, count_d;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = store[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // storage carries no reset; enabled only on a real push
  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= wdata;
  end

  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(push && !flush));
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/pbq_regbank.sv
module pbq_regbank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic word_en;
    assign word_en = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q[g] <= '0;
      else if (word_en) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/pbq_worker.sv
module pbq_worker
  import pbq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int PROC_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              q_empty,
  input  logic              q_we,
  input  logic [ADDR_W-1:0] q_adr,
  input  logic [DATA_W-1:0] q_dat,
  output logic              q_pop,
  output logic              bank_wr,
  output logic [ADDR_W-1:0] bank_adr,
  output logic [DATA_W-1:0] bank_wdat,
  input  logic [DATA_W-1:0] bank_rdat,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o
);
  localparam int CNT_W = (PROC_CYCLES > 1) ? $clog2(PROC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROC_CYCLES - 1);

  wk_state_e         state, state_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic              cur_we, cur_we_d;
  logic [ADDR_W-1:0] cur_adr, cur_adr_d;
  logic [DATA_W-1:0] cur_dat, cur_dat_d;
  logic              done;
  logic              ack_d;
  logic [DATA_W-1:0] dat_d;

  assign done  = (state == WK_BUSY) && (cnt == '0) && !flush;
  assign q_pop = !flush && !q_empty && ((state == WK_IDLE) || done);

  assign bank_wr   = done && cur_we;
  assign bank_adr  = cur_adr;
  assign bank_wdat = cur_dat;

  always_comb begin
    state_d   = state;
    cnt_d     = cnt;
    cur_we_d  = cur_we;
    cur_adr_d = cur_adr;
    cur_dat_d = cur_dat;
    if (flush) begin
      state_d = WK_IDLE;
      cnt_d   = '0;
    end else if (q_pop) begin
      state_d   = WK_BUSY;
      cnt_d     = CNT_LOAD;
      cur_we_d  = q_we;
      cur_adr_d = q_adr;
      cur_dat_d = q_dat;
    end else if (done) begin
      state_d = WK_IDLE;
    end else if (state == WK_BUSY) begin
      cnt_d = cnt - 1'b1;
    end
    ack_d = done;
    dat_d = (done && !cur_we) ? bank_rdat : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WK_IDLE;
      cnt     <= '0;
      cur_we  <= 1'b0;
      cur_adr <= '0;
      cur_dat <= '0;
      ack_o   <= 1'b0;
      dat_o   <= '0;
    end else begin
      state   <= state_d;
      cnt     <= cnt_d;
      cur_we  <= cur_we_d;
      cur_adr <= cur_adr_d;
      cur_dat <= cur_dat_d;
      ack_o   <= ack_d;
      dat_o   <= dat_d;
    end
  end

  a_r7_no_ack_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ack_o);
  a_r5_data_zero_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (dat_o == '0));
  a_r3_ack_follows_work: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(state == WK_BUSY));
  a_r4_pop_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WK_BUSY && cnt != '0) |-> !q_pop);

  if (PROC_CYCLES > 1) begin : g_pulse_chk
    a_r4_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);
  end
endmodule

// File: rtl/pbq_slave.sv
module pbq_slave #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 4,
  parameter int PROC_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              stall_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o
);
  localparam int REQ_W = 1 + ADDR_W + DATA_W;

  logic              flush, accept;
  logic              q_empty, q_full, q_pop;
  logic [REQ_W-1:0]  q_head;
  logic              bank_wr;
  logic [ADDR_W-1:0] bank_adr;
  logic [DATA_W-1:0] bank_wdat, bank_rdat;

  assign flush   = !cyc_i;
  assign stall_o = q_full;
  assign accept  = cyc_i && stb_i && !q_full;

  pbq_fifo #(.WIDTH(REQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (accept),
    .wdata ({we_i, adr_i, dat_i}),
    .pop   (q_pop),
    .rdata (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  pbq_worker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROC_CYCLES(PROC_CYCLES)) u_worker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .q_empty   (q_empty),
    .q_we      (q_head[REQ_W-1]),
    .q_adr     (q_head[DATA_W +: ADDR_W]),
    .q_dat     (q_head[DATA_W-1:0]),
    .q_pop     (q_pop),
    .bank_wr   (bank_wr),
    .bank_adr  (bank_adr),
    .bank_wdat (bank_wdat),
    .bank_rdat (bank_rdat),
    .ack_o     (ack_o),
    .dat_o     (dat_o)
  );

  pbq_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_wr),
    .wr_addr (bank_adr),
    .wr_data (bank_wdat),
    .rd_addr (bank_adr),
    .rd_data (bank_rdat)
  );

  a_r1_stall_means_full: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && cyc_i) |=> (stall_o || ack_o || $past(q_pop)));
  a_r8_quiet_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ack_o && !stall_o));
endmodule

// File: tb/pbq_slave_test.sv
`timescale 1ns/1ps
module pbq_slave_test;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int PROC   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] adr_i = '0;
  logic [DATA_W-1:0] dat_i = '0;
  logic stall_o, ack_o;
  logic [DATA_W-1:0] dat_o;

  always #2.5 clk = ~clk;

  pbq_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .PROC_CYCLES(PROC)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .stall_o(stall_o), .ack_o(ack_o), .dat_o(dat_o)
  );

  typedef struct {
    logic              we;
    logic [ADDR_W-1:0] adr;
    logic [DATA_W-1:0] dat;
    int                step;
  } req_t;

  req_t              pend[$];
  logic [DATA_W-1:0] mbank [1 << ADDR_W];
  int checks = 0, fails = 0;
  int stepno = 0;
  int last_lat = -1, last_ack_step = -1, ack_gap = -1;
  int done_flag = 0;

  function automatic logic [DATA_W-1:0] expect_data(input req_t r);
    return r.we ? '0 : mbank[r.adr];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (step %0d)", req, what, act, exp, stepno);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic w,
                      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic st0;
    req_t r;
    @(negedge clk);
    stepno++;
    if (ack_o) begin
      if (pend.size() == 0) begin
        check(1'b0, "R4", "ack with nothing pending", 1, 0);
      end else begin
        r = pend.pop_front();
        check(dat_o == expect_data(r), r.we ? "R5" : "R6", "ack data", dat_o, expect_data(r));
        if (r.we) mbank[r.adr] = r.dat;
        last_lat = stepno - r.step;
        ack_gap = (last_ack_step >= 0) ? stepno - last_ack_step : -1;
        last_ack_step = stepno;
      end
    end else begin
      check(dat_o == '0, "R5", "dat_o zero while ack low", dat_o, '0);
    end
    st0 = stall_o;
    if (st0) check(pend.size() >= DEPTH, "R2", "stall with room", pend.size(), DEPTH);
    else     check(pend.size() <= DEPTH, "R2", "no stall when full", pend.size(), DEPTH);
    cyc_i = c; stb_i = s; we_i = w; adr_i = a; dat_i = d;
    #1;
    check(stall_o == st0, "R1", "stall moved with inputs", stall_o, st0);
    if (!c) pend.delete();
    else if (s && !st0) begin
      r.we = w; r.adr = a; r.dat = d; r.step = stepno;
      pend.push_back(r);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && pend.size() != 0; i++) step(1, 0, 0, '0, '0);
    step(1, 0, 0, '0, '0);
    check(pend.size() == 0, "R4", "requests left unacknowledged", pend.size(), 0);
  endtask

  initial begin
    #100000;
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    bit saw_stall;
    seed_dummy = $urandom(32'd1977);
    for (int i = 0; i < (1 << ADDR_W); i++) mbank[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(!stall_o, "R8", "stall after reset", stall_o, 0);
    check(!ack_o, "R8", "ack after reset", ack_o, 0);
    check(dat_o == '0, "R8", "dat after reset", dat_o, 0);
    // R8 bank reads zero (model bank is zero)
    for (int i = 0; i < (1 << ADDR_W); i++) step(1, 1, 0, ADDR_W'(i), '0);
    drain();

    // R3 latency on an empty slave
    step(1, 1, 0, 4'd5, '0);
    step(1, 0, 0, '0, '0);
    drain();
    check(last_lat == PROC + 2, "R3", "single latency in steps", last_lat, PROC + 2);

    // R3 back-to-back spacing, R6 write then read
    step(1, 1, 1, 4'd7, 32'hCAFE_0007);
    step(1, 1, 0, 4'd7, '0);
    step(1, 1, 0, 4'd7, '0);
    drain();
    check(ack_gap == PROC, "R3", "back-to-back ack spacing", ack_gap, PROC);
    check(mbank[7] == 32'hCAFE_0007, "R6", "write reached model", mbank[7], 32'hCAFE_0007);

    // R2 continuous strobes fill the queue
    saw_stall = 0;
    for (int i = 0; i < 12; i++) begin
      step(1, 1, 1, ADDR_W'(i), 32'h1000 + i);
      if (stall_o) saw_stall = 1;
    end
    check(saw_stall, "R2", "stall never rose under burst", saw_stall, 1);
    drain();

    // R7 flush discards a pending write
    step(1, 1, 1, 4'd3, 32'hDEAD_BEEF);
    step(1, 1, 1, 4'd9, 32'h0BAD_F00D);
    step(0, 0, 0, '0, '0);
    for (int i = 0; i < PROC + 3; i++) step(1, 0, 0, '0, '0);
    step(1, 1, 0, 4'd3, '0);
    step(1, 1, 0, 4'd9, '0);
    drain();
    check(mbank[3] != 32'hDEAD_BEEF, "R7", "flushed write landed", mbank[3], 0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic c;
      c = ($urandom % 60) != 0;
      step(c, ($urandom % 2) == 0, ($urandom % 2) == 0,
           ADDR_W'($urandom), $urandom);
    end
    drain();

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule